// File: doc/BRIEF.md
# Dual-Channel FIFO Readiness Status Register

This block folds the readiness of four FIFOs into one 8-bit read-only status byte. The four FIFOs are the transmit and receive FIFOs of two UART channels. For each channel it receives the TX free-space count, the RX fill count, a character-timeout flag from the receiver, and two sources of trigger level. One source is a 2-bit coded level and the other is a 4-bit programmable level. Each channel and direction gets its own effective trigger level. The block compares the counts against that level and presents the result combinationally on `rdy_status`.

The status byte is also visible through the host register port at address 7, but only when the selected channel has status access enabled and is not in loopback. When access is not granted, the same address reaches that channel's 8-bit scratch register, which is read/write. The read data is registered: `rdata` updates on the clock edge that samples `rd_en` and holds until the next read.

Top module: `fifo_rdy_status`

## Requirements
- R1: `rdy_status[0]` (channel A) and `rdy_status[1]` (channel B) are 1 exactly when that channel's TX free count is greater than or equal to its effective TX trigger level.
- R2: `rdy_status[4]` (channel A) and `rdy_status[5]` (channel B) are 1 exactly when that channel's RX fill count is greater than or equal to its effective RX trigger level, or when its timeout flag is 1.
- R3: Bits 2, 3, 6 and 7 of `rdy_status` are always 0.
- R4: When a channel's programmable level for a direction is 0, the 2-bit code sets the level. For a 64-entry FIFO, codes 0/1/2/3 give RX levels 8/16/56/60 and TX levels 8/16/32/56.
- R5: When the programmable level field is nonzero, the effective level is four times its value.
- R6: The selected channel is A when `cs_a_n` is 0, otherwise B. Status access is granted when either chip select is 0, the selected channel's `rdy_en` bit is 1 and its `loopback` bit is 0. A read of address 7 under status access loads `rdy_status` into `rdata` on the sampling edge.
- R7: Without status access, reads and writes at address 7 reach the selected channel's scratch register. Each channel has its own scratch register.
- R8: A write to address 7 under status access changes no scratch register.
- R9: After reset `rdata` is 0 and both scratch registers are 0.
- R10: A read of any address other than 7 with a chip select low returns 0. A read with both chip selects high, or any cycle without `rd_en`, leaves `rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_a_n | input | 1 | Channel A chip select, active low |
| cs_b_n | input | 1 | Channel B chip select, active low |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rdy_en | input | 2 | Per-channel status access enable (bit 0 = A) |
| loopback | input | 2 | Per-channel loopback mode (bit 0 = A) |
| tx_free | input | 14 | TX free counts, 7 bits per channel, A in low bits |
| rx_fill | input | 14 | RX fill counts, 7 bits per channel, A in low bits |
| rx_tmo | input | 2 | Per-channel character timeout flag |
| fcr_tx_code | input | 4 | Coded TX level, 2 bits per channel |
| fcr_rx_code | input | 4 | Coded RX level, 2 bits per channel |
| tlr_tx | input | 8 | Programmable TX level, 4 bits per channel |
| tlr_rx | input | 8 | Programmable RX level, 4 bits per channel |
| rdy_status | output | 8 | Combinational readiness byte |

## Verification
The bench sets counts exactly at each trigger level and one below it, for every code and for the smallest and largest programmable values. A comparison of the wrong sense, or the wrong level table, flips a bit at one of those edges. It holds the timeout with empty FIFOs, so an RX path that ignores the timeout reads 0. It writes the scratch register while status access is on, then turns access off and reads the scratch. A design that lets the write through shows the written byte instead of 0. It also grants or denies access through loopback and through channel B's own enable. A decoder that looks at the wrong channel returns the scratch byte where status is expected.

// File: rtl/fifo_rdy_pkg.sv
package fifo_rdy_pkg;
    localparam int NCH = 2;

    // coded level as a fraction of depth, in sixteenths
    function automatic int code_sixteenths(input bit is_tx, input int code);
        int r;
        if (is_tx) begin
            case (code)
                0: r = 2;
                1: r = 4;
                2: r = 8;
                default: r = 14;
            endcase
        end else begin
            case (code)
                0: r = 2;
                1: r = 4;
                2: r = 14;
                default: r = 15;
            endcase
        end
        return r;
    endfunction
endpackage

// File: rtl/fifo_rdy_trig.sv
module fifo_rdy_trig #(
    parameter bit IS_TX = 1'b1,
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [1:0]    code,
    input  logic [3:0]    tlr,
    output logic [CW-1:0] level
);
    import fifo_rdy_pkg::*;

    logic [CW-1:0] coded [4];

    for (genvar c = 0; c < 4; c++) begin : g_code
        localparam int LVL = DEPTH * code_sixteenths(IS_TX, c) / 16;
        assign coded[c] = CW'(LVL);
    end

    always_comb begin
        if (tlr == 4'd0) level = coded[code];
        else             level = CW'({tlr, 2'b00});
    end
endmodule

// File: rtl/fifo_rdy_chan.sv
module fifo_rdy_chan #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] tx_free,
    input  logic [CW-1:0] rx_fill,
    input  logic          rx_tmo,
    input  logic [1:0]    tx_code,
    input  logic [1:0]    rx_code,
    input  logic [3:0]    tx_tlr,
    input  logic [3:0]    rx_tlr,
    output logic          tx_rdy,
    output logic          rx_rdy
);
    logic [CW-1:0] tx_lvl;
    logic [CW-1:0] rx_lvl;

    fifo_rdy_trig #(.IS_TX(1'b1), .DEPTH(DEPTH)) u_tx_trig (
        .code (tx_code),
        .tlr  (tx_tlr),
        .level(tx_lvl)
    );

    fifo_rdy_trig #(.IS_TX(1'b0), .DEPTH(DEPTH)) u_rx_trig (
        .code (rx_code),
        .tlr  (rx_tlr),
        .level(rx_lvl)
    );

    assign tx_rdy = (tx_free >= tx_lvl);
    assign rx_rdy = (rx_fill >= rx_lvl) || rx_tmo;
endmodule

// File: rtl/fifo_rdy_host.sv
module fifo_rdy_host #(
    parameter int NCH = 2,
    parameter int DW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_a_n,
    input  logic           cs_b_n,
    input  logic [2:0]     addr,
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic [DW-1:0]  wdata,
    input  logic [NCH-1:0] rdy_en,
    input  logic [NCH-1:0] loopback,
    input  logic [DW-1:0]  status,
    output logic [DW-1:0]  rdata
);
    localparam logic [2:0] STAT_ADDR = 3'h7;

    typedef struct packed {
        logic [NCH-1:0][DW-1:0] scratch;
        logic [DW-1:0]          rdata;
    } host_t;

    host_t st_d, st_q;

    logic sel;
    logic any_cs;
    logic stat_acc;
    logic hit;

    always_comb begin
        sel      = cs_a_n;
        any_cs   = !cs_a_n || !cs_b_n;
        stat_acc = any_cs && rdy_en[sel] && !loopback[sel];
        hit      = (addr == STAT_ADDR);

        st_d = st_q;
        if (any_cs && wr_en && hit && !stat_acc)
            st_d.scratch[sel] = wdata;
        if (any_cs && rd_en) begin
            if (!hit)          st_d.rdata = '0;
            else if (stat_acc) st_d.rdata = status;
            else               st_d.rdata = st_q.scratch[sel];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;
endmodule

// File: rtl/fifo_rdy_status.sv
module fifo_rdy_status #(
    parameter int DEPTH = 64,
    localparam int NCH  = fifo_rdy_pkg::NCH,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_a_n,
    input  logic              cs_b_n,
    input  logic [2:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [NCH-1:0]    rdy_en,
    input  logic [NCH-1:0]    loopback,
    input  logic [NCH*CW-1:0] tx_free,
    input  logic [NCH*CW-1:0] rx_fill,
    input  logic [NCH-1:0]    rx_tmo,
    input  logic [NCH*2-1:0]  fcr_tx_code,
    input  logic [NCH*2-1:0]  fcr_rx_code,
    input  logic [NCH*4-1:0]  tlr_tx,
    input  logic [NCH*4-1:0]  tlr_rx,
    output logic [7:0]        rdy_status
);
    logic [NCH-1:0] tx_rdy;
    logic [NCH-1:0] rx_rdy;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        fifo_rdy_chan #(.DEPTH(DEPTH)) u_chan (
            .tx_free(tx_free[ch*CW +: CW]),
            .rx_fill(rx_fill[ch*CW +: CW]),
            .rx_tmo (rx_tmo[ch]),
            .tx_code(fcr_tx_code[ch*2 +: 2]),
            .rx_code(fcr_rx_code[ch*2 +: 2]),
            .tx_tlr (tlr_tx[ch*4 +: 4]),
            .rx_tlr (tlr_rx[ch*4 +: 4]),
            .tx_rdy (tx_rdy[ch]),
            .rx_rdy (rx_rdy[ch])
        );
    end

    always_comb begin
        rdy_status      = '0;
        rdy_status[1:0] = tx_rdy;
        rdy_status[5:4] = rx_rdy;
    end

    fifo_rdy_host #(.NCH(NCH), .DW(8)) u_host (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_a_n  (cs_a_n),
        .cs_b_n  (cs_b_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wdata   (wdata),
        .rdy_en  (rdy_en),
        .loopback(loopback),
        .status  (rdy_status),
        .rdata   (rdata)
    );
endmodule

// File: rtl/fifo_rdy_chk.sv
module fifo_rdy_chk #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_a_n,
    input logic          cs_b_n,
    input logic [2:0]    addr,
    input logic          rd_en,
    input logic [1:0]    rdy_en,
    input logic [1:0]    loopback,
    input logic [2*CW-1:0] tx_free,
    input logic [2*CW-1:0] rx_fill,
    input logic [1:0]    rx_tmo,
    input logic [7:0]    rdy_status,
    input logic [7:0]    rdata
);
    logic acc_a;
    logic acc_b;
    assign acc_a = !cs_a_n && rdy_en[0] && !loopback[0];
    assign acc_b = cs_a_n && !cs_b_n && rdy_en[1] && !loopback[1];

    // R1
    tx_full_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_free[CW-1:0] == CW'(DEPTH)) |-> rdy_status[0]);

    // R2
    rx_tmo_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_tmo[1] |-> rdy_status[5]);

    // R2
    rx_empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fill[CW-1:0] == '0 && !rx_tmo[0]) |-> !rdy_status[4]);

    // R3
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_status & 8'hCC) == 8'h00);

    // R6
    stat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'h7 && (acc_a || acc_b)) |=> rdata == $past(rdy_status));

    // R10
    hold_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || (cs_a_n && cs_b_n)) |=> $stable(rdata));
endmodule

bind fifo_rdy_status fifo_rdy_chk #(.DEPTH(DEPTH)) u_fifo_rdy_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_a_n    (cs_a_n),
    .cs_b_n    (cs_b_n),
    .addr      (addr),
    .rd_en     (rd_en),
    .rdy_en    (rdy_en),
    .loopback  (loopback),
    .tx_free   (tx_free),
    .rx_fill   (rx_fill),
    .rx_tmo    (rx_tmo),
    .rdy_status(rdy_status),
    .rdata     (rdata)
);

// File: tb/test_fifo_rdy_status.sv
module test_fifo_rdy_status;
    localparam int CW = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_a_n = 1'b1, cs_b_n = 1'b1;
    logic [2:0] addr = '0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] rdy_en = '0, loopback = '0, rx_tmo = '0;
    logic [13:0] tx_free = '0, rx_fill = '0;
    logic [3:0] fcr_tx_code = '0, fcr_rx_code = '0;
    logic [7:0] tlr_tx = '0, tlr_rx = '0;
    logic [7:0] rdy_status;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fifo_rdy_status i_fifo_rdy_status (
        .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
        .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
        .rdata(rdata), .rdy_en(rdy_en), .loopback(loopback),
        .tx_free(tx_free), .rx_fill(rx_fill), .rx_tmo(rx_tmo),
        .fcr_tx_code(fcr_tx_code), .fcr_rx_code(fcr_rx_code),
        .tlr_tx(tlr_tx), .tlr_rx(tlr_rx), .rdy_status(rdy_status)
    );

    typedef struct packed {
        logic [6:0] txa, txb, rxa, rxb;
        logic [1:0] tmo;
        logic [1:0] ftxa, ftxb, frxa, frxb;
        logic [3:0] ttxa, ttxb, trxa, trxb;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{7'd8,  7'd7,  7'd8,  7'd7,  2'b00, 2'd0, 2'd0, 2'd0, 2'd0, 4'd0,  4'd0,  4'd0,  4'd0},
        '{7'd16, 7'd15, 7'd16, 7'd15, 2'b00, 2'd1, 2'd1, 2'd1, 2'd1, 4'd0,  4'd0,  4'd0,  4'd0},
        '{7'd32, 7'd31, 7'd56, 7'd55, 2'b00, 2'd2, 2'd2, 2'd2, 2'd2, 4'd0,  4'd0,  4'd0,  4'd0},
        '{7'd56, 7'd55, 7'd60, 7'd59, 2'b00, 2'd3, 2'd3, 2'd3, 2'd3, 4'd0,  4'd0,  4'd0,  4'd0},
        '{7'd31, 7'd32, 7'd55, 7'd56, 2'b00, 2'd2, 2'd2, 2'd2, 2'd2, 4'd0,  4'd0,  4'd0,  4'd0},
        '{7'd4,  7'd3,  7'd4,  7'd3,  2'b00, 2'd3, 2'd3, 2'd3, 2'd3, 4'd1,  4'd1,  4'd1,  4'd1},
        '{7'd60, 7'd59, 7'd60, 7'd59, 2'b00, 2'd0, 2'd0, 2'd0, 2'd0, 4'd15, 4'd15, 4'd15, 4'd15},
        '{7'd0,  7'd0,  7'd0,  7'd0,  2'b11, 2'd0, 2'd0, 2'd0, 2'd0, 4'd0,  4'd0,  4'd0,  4'd0},
        '{7'd64, 7'd64, 7'd64, 7'd64, 2'b00, 2'd3, 2'd3, 2'd3, 2'd3, 4'd0,  4'd0,  4'd0,  4'd0},
        '{7'd40, 7'd20, 7'd0,  7'd7,  2'b01, 2'd2, 2'd1, 2'd0, 2'd0, 4'd10, 4'd0,  4'd0,  4'd2}
    };

    // R4, R5: levels from the requirement tables
    function automatic int lvl(input bit is_tx, input int code, input int tlr);
        int tx_tab [4] = '{8, 16, 32, 56};
        int rx_tab [4] = '{8, 16, 56, 60};
        if (tlr != 0) return 4 * tlr;
        return is_tx ? tx_tab[code] : rx_tab[code];
    endfunction

    function automatic logic [7:0] model(input vec_t v);
        logic [7:0] s = '0;
        s[0] = int'(v.txa) >= lvl(1'b1, int'(v.ftxa), int'(v.ttxa));
        s[1] = int'(v.txb) >= lvl(1'b1, int'(v.ftxb), int'(v.ttxb));
        s[4] = (int'(v.rxa) >= lvl(1'b0, int'(v.frxa), int'(v.trxa))) || v.tmo[0];
        s[5] = (int'(v.rxb) >= lvl(1'b0, int'(v.frxb), int'(v.trxb))) || v.tmo[1];
        return s;
    endfunction

    task automatic apply(input vec_t v);
        tx_free = {v.txb, v.txa};
        rx_fill = {v.rxb, v.rxa};
        rx_tmo = v.tmo;
        fcr_tx_code = {v.ftxb, v.ftxa};
        fcr_rx_code = {v.frxb, v.frxa};
        tlr_tx = {v.ttxb, v.ttxa};
        tlr_rx = {v.trxb, v.trxa};
    endtask

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // one host access; inputs change on the falling edge
    task automatic access(input logic csa, input logic csb, input logic [2:0] a,
                          input logic wr, input logic rd, input logic [7:0] d);
        @(negedge clk);
        cs_a_n = csa; cs_b_n = csb; addr = a; wr_en = wr; rd_en = rd; wdata = d;
        @(negedge clk);
        cs_a_n = 1'b1; cs_b_n = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] prev;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 rdata after reset", rdata, 8'h00);
        rst_n = 1'b1;

        // R9: scratch A and B start at 0 (no status access)
        access(1'b0, 1'b1, 3'h7, 1'b0, 1'b1, 8'h00);
        chk("R9 scratch A reset", rdata, 8'h00);
        access(1'b1, 1'b0, 3'h7, 1'b0, 1'b1, 8'h00);
        chk("R9 scratch B reset", rdata, 8'h00);

        // R1 R2 R3 R4 R5: vector walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VECS[i]);
            #1;
            chk("R1 R2 R3 R4 R5 status vector", rdy_status, model(VECS[i]));
        end

        // R6: status read via channel A access
        apply(VECS[9]);
        rdy_en = 2'b01;
        access(1'b0, 1'b1, 3'h7, 1'b0, 1'b1, 8'h00);
        chk("R6 status read A", rdata, model(VECS[9]));

        // R8: write while access granted is ignored
        access(1'b0, 1'b1, 3'h7, 1'b1, 1'b0, 8'h5A);
        rdy_en = 2'b00;
        access(1'b0, 1'b1, 3'h7, 1'b0, 1'b1, 8'h00);
        chk("R8 scratch A untouched", rdata, 8'h00);

        // R7: scratch write and read, per channel
        access(1'b0, 1'b1, 3'h7, 1'b1, 1'b0, 8'hA5);
        access(1'b1, 1'b0, 3'h7, 1'b1, 1'b0, 8'h3C);
        access(1'b0, 1'b1, 3'h7, 1'b0, 1'b1, 8'h00);
        chk("R7 scratch A", rdata, 8'hA5);
        access(1'b1, 1'b0, 3'h7, 1'b0, 1'b1, 8'h00);
        chk("R7 scratch B", rdata, 8'h3C);

        // R7: loopback on channel A denies status access
        apply(VECS[8]);
        rdy_en = 2'b11;
        loopback = 2'b01;
        access(1'b0, 1'b1, 3'h7, 1'b0, 1'b1, 8'h00);
        chk("R7 loopback gives scratch", rdata, 8'hA5);

        // R6: channel B uses its own enable and loopback
        access(1'b1, 1'b0, 3'h7, 1'b0, 1'b1, 8'h00);
        chk("R6 status read B", rdata, model(VECS[8]));
        rdy_en = 2'b01;
        loopback = 2'b00;
        access(1'b1, 1'b0, 3'h7, 1'b0, 1'b1, 8'h00);
        chk("R7 B disabled gives scratch", rdata, 8'h3C);

        // R10: other address reads 0
        access(1'b0, 1'b1, 3'h2, 1'b0, 1'b1, 8'h00);
        chk("R10 other address", rdata, 8'h00);

        // R10: no chip select leaves rdata unchanged
        access(1'b1, 1'b0, 3'h7, 1'b0, 1'b1, 8'h00);
        prev = rdata;
        access(1'b1, 1'b1, 3'h7, 1'b0, 1'b1, 8'h00);
        chk("R10 no select holds", rdata, prev);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule